// File: doc/BRIEF.md
# Flash Interface Strobe Clock Generator

This block produces the slow interface clock used to pace a flash memory bus, along with two strobe waveforms derived from it. The interface clock comes from the peripheral clock through a programmable divider. A serial/command strobe always follows the interface clock. A write-enable strobe either follows it (NAND-type memory) or runs at half its rate (AND-type memory).

Clock configuration covers the coarse and fine divider fields and the memory type. Software may change it only while the block is in module-stop. A configuration write that arrives while the block is running is dropped and raises a sticky error flag. Writing 1 to the clear input removes the flag.

While stopped, the divider is held at zero and every output is low. After release, the interface clock starts with a low phase of full length, so no shortened pulse ever reaches the flash pins.

Top module: `flash_strobe_clkgen`

## Requirements
- R1: After reset the block is in module-stop, the ratio is 1, NAND mode is selected, `cfg_err_o` is 0 and all three clock outputs are low. Releasing module-stop without any configuration write runs at ratio 1.
- R2: The ratio is N = 2^coarse, doubled when the fine bit is 1, giving N from 1 to 16. While running, `fclk_o` toggles once every N peripheral clock cycles, so its period is 2N cycles.
- R3: The module-stop state is `stop_i` as sampled on the previous clock edge. From the second edge after `stop_i` is first sampled high, `fclk_o`, `sc_strobe_o` and `we_strobe_o` are low and stay low for as long as the block is stopped.
- R4: Let E0 be the first edge that samples `stop_i` low. `fclk_o` stays low until edge E0+N, rises at that edge, and then follows R2.
- R5: In NAND mode (`cfg_and_i` = 0 when written), `we_strobe_o` equals `fclk_o` in every cycle.
- R6: `sc_strobe_o` always equals `fclk_o`. In AND mode (`cfg_and_i` = 1 when written), `we_strobe_o` toggles on each rising edge of `fclk_o`, in the same cycle, and does not change at any other time.
- R7: A write (`cfg_we_i` = 1) is accepted while the block is in module-stop, and the new ratio and mode apply from the next release.
- R8: A write made while the block is running leaves the ratio and mode unchanged, so the waveform continues undisturbed, and it sets `cfg_err_o` on the next edge.
- R9: `err_clr_i` = 1 clears `cfg_err_o` on the next edge. A rejected write in the same cycle takes priority and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Module-stop request |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_coarse_i | input | COARSE_W | Coarse divider select (exponent) |
| cfg_fine_i | input | 1 | Fine select; doubles the ratio |
| cfg_and_i | input | 1 | Memory type: 1 = AND, 0 = NAND |
| err_clr_i | input | 1 | Write-1-to-clear for the error flag |
| fclk_o | output | 1 | Divided interface clock |
| sc_strobe_o | output | 1 | Serial/command strobe |
| we_strobe_o | output | 1 | Write-enable strobe |
| cfg_err_o | output | 1 | Sticky flag for a rejected configuration write |

## Verification
A wrong divider count or limit moves the first rising edge of `fclk_o` away from edge E0+N. This is visible within 16 cycles of release, and every later edge is shifted as well. A wrong phase in the half-rate strobe shows on `we_strobe_o` at the first or second rising edge of `fclk_o`. A configuration register that takes a write while the block is running shows up as a changed period in the very next half-period. A stop gate that does not work leaves an output high two edges after stop is requested.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic {
        MEM_NAND = 1'b0,
        MEM_AND  = 1'b1
    } mem_kind_e;

    localparam int unsigned COARSE_W_DEF = 2;

endpackage

// File: rtl/fsc_cfg_regs.sv
module fsc_cfg_regs
    import fsc_pkg::*;
#(
    parameter int unsigned COARSE_W = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                stop_i,
    input  logic                we_i,
    input  logic [COARSE_W-1:0] coarse_i,
    input  logic                fine_i,
    input  logic                and_i,
    input  logic                clr_i,
    output logic                stop_o,
    output logic [COARSE_W-1:0] coarse_o,
    output logic                fine_o,
    output mem_kind_e           mode_o,
    output logic                err_o
);

    typedef struct packed {
        logic                stop;
        logic [COARSE_W-1:0] coarse;
        logic                fine;
        mem_kind_e           mode;
        logic                err;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic       accept, reject;

    always_comb begin
        st_d      = st_q;
        accept    = we_i &  st_q.stop;
        reject    = we_i & ~st_q.stop;
        st_d.stop = stop_i;
        if (accept) begin
            st_d.coarse = coarse_i;
            st_d.fine   = fine_i;
            st_d.mode   = and_i ? MEM_AND : MEM_NAND;
        end
        st_d.err = reject | (st_q.err & ~clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.stop   <= 1'b1;
            st_q.coarse <= '0;
            st_q.fine   <= 1'b0;
            st_q.mode   <= MEM_NAND;
            st_q.err    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stop_o   = st_q.stop;
    assign coarse_o = st_q.coarse;
    assign fine_o   = st_q.fine;
    assign mode_o   = st_q.mode;
    assign err_o    = st_q.err;

endmodule

// File: rtl/fsc_ratio_dec.sv
module fsc_ratio_dec #(
    parameter int unsigned COARSE_W = 2,
    parameter int unsigned CNT_W    = 4
) (
    input  logic [COARSE_W-1:0] coarse_i,
    input  logic                fine_i,
    output logic [CNT_W-1:0]    lim_o
);

    logic [CNT_W:0] ratio;
    logic [CNT_W:0] ratio_m1;

    always_comb begin
        ratio = {{CNT_W{1'b0}}, 1'b1} << coarse_i;
        if (fine_i) begin
            ratio = ratio << 1;
        end
        ratio_m1 = ratio - {{CNT_W{1'b0}}, 1'b1};
        lim_o    = ratio_m1[CNT_W-1:0];
    end

endmodule

// File: rtl/fsc_div_core.sv
module fsc_div_core #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hold_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             tick_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             wrap;

    always_comb begin
        wrap = (cnt_q == lim_i);
        if (hold_i) begin
            cnt_d = '0;
        end else if (wrap) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign tick_o = ~hold_i & wrap;

endmodule

// File: rtl/fsc_strobe_gen.sv
module fsc_strobe_gen
    import fsc_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      hold_i,
    input  logic      tick_i,
    input  mem_kind_e mode_i,
    output logic      fclk_o,
    output logic      sc_o,
    output logic      we_o
);

    typedef struct packed {
        logic fclk;
        logic sc;
        logic we;
    } strobe_t;

    strobe_t sb_d, sb_q;

    always_comb begin
        sb_d = sb_q;
        if (hold_i) begin
            sb_d = '0;
        end else if (tick_i) begin
            sb_d.fclk = ~sb_q.fclk;
            sb_d.sc   = ~sb_q.sc;
            if (mode_i == MEM_NAND) begin
                sb_d.we = ~sb_q.fclk;
            end else begin
                sb_d.we = sb_q.we ^ ~sb_q.fclk;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sb_q <= '0;
        else         sb_q <= sb_d;
    end

    assign fclk_o = sb_q.fclk;
    assign sc_o   = sb_q.sc;
    assign we_o   = sb_q.we;

endmodule

// File: rtl/flash_strobe_clkgen.sv
module flash_strobe_clkgen
    import fsc_pkg::*;
#(
    parameter int unsigned COARSE_W = COARSE_W_DEF
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                stop_i,
    input  logic                cfg_we_i,
    input  logic [COARSE_W-1:0] cfg_coarse_i,
    input  logic                cfg_fine_i,
    input  logic                cfg_and_i,
    input  logic                err_clr_i,
    output logic                fclk_o,
    output logic                sc_strobe_o,
    output logic                we_strobe_o,
    output logic                cfg_err_o
);

    localparam int unsigned CNT_W = 1 << COARSE_W;

    logic                stop_q;
    logic [COARSE_W-1:0] coarse_q;
    logic                fine_q;
    mem_kind_e           mode_q;
    logic [CNT_W-1:0]    lim;
    logic                tick;

    fsc_cfg_regs #(.COARSE_W(COARSE_W)) u_cfg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .stop_i   (stop_i),
        .we_i     (cfg_we_i),
        .coarse_i (cfg_coarse_i),
        .fine_i   (cfg_fine_i),
        .and_i    (cfg_and_i),
        .clr_i    (err_clr_i),
        .stop_o   (stop_q),
        .coarse_o (coarse_q),
        .fine_o   (fine_q),
        .mode_o   (mode_q),
        .err_o    (cfg_err_o)
    );

    fsc_ratio_dec #(.COARSE_W(COARSE_W), .CNT_W(CNT_W)) u_dec (
        .coarse_i (coarse_q),
        .fine_i   (fine_q),
        .lim_o    (lim)
    );

    fsc_div_core #(.CNT_W(CNT_W)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hold_i (stop_q),
        .lim_i  (lim),
        .tick_o (tick)
    );

    fsc_strobe_gen u_strb (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hold_i (stop_q),
        .tick_i (tick),
        .mode_i (mode_q),
        .fclk_o (fclk_o),
        .sc_o   (sc_strobe_o),
        .we_o   (we_strobe_o)
    );

endmodule

// File: rtl/fsc_checker.sv
module fsc_checker
    import fsc_pkg::*;
#(
    parameter int unsigned COARSE_W = 2
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                stop_q,
    input logic                cfg_we_i,
    input logic                err_clr_i,
    input logic [COARSE_W-1:0] coarse_q,
    input logic                fine_q,
    input mem_kind_e           mode_q,
    input logic                fclk_o,
    input logic                sc_strobe_o,
    input logic                we_strobe_o,
    input logic                cfg_err_o
);

    assert_stop_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_q |=> (!fclk_o && !sc_strobe_o && !we_strobe_o));

    assert_reject_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && !stop_q) |=> cfg_err_o);

    assert_reject_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && !stop_q) |=> ($stable(coarse_q) && $stable(fine_q) && $stable(mode_q)));

    assert_err_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_clr_i && !(cfg_we_i && !stop_q)) |=> !cfg_err_o);

    assert_nand_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == MEM_NAND) |-> (we_strobe_o == fclk_o));

    assert_sc_track_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |-> (sc_strobe_o == fclk_o));

    assert_and_align_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == MEM_AND && !$past(stop_q) && !$stable(we_strobe_o)) |-> $rose(fclk_o));

endmodule

bind flash_strobe_clkgen fsc_checker #(.COARSE_W(COARSE_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stop_q      (stop_q),
    .cfg_we_i    (cfg_we_i),
    .err_clr_i   (err_clr_i),
    .coarse_q    (coarse_q),
    .fine_q      (fine_q),
    .mode_q      (mode_q),
    .fclk_o      (fclk_o),
    .sc_strobe_o (sc_strobe_o),
    .we_strobe_o (we_strobe_o),
    .cfg_err_o   (cfg_err_o)
);

// File: tb/flash_strobe_clkgen_tb.sv
module flash_strobe_clkgen_tb;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       stop_i = 1'b1;
    logic       cfg_we_i = 1'b0;
    logic [1:0] cfg_coarse_i = 2'd0;
    logic       cfg_fine_i = 1'b0;
    logic       cfg_and_i = 1'b0;
    logic       err_clr_i = 1'b0;
    logic       fclk_o, sc_strobe_o, we_strobe_o, cfg_err_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk_i = ~clk_i;

    flash_strobe_clkgen #(.COARSE_W(2)) u_dut (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .stop_i       (stop_i),
        .cfg_we_i     (cfg_we_i),
        .cfg_coarse_i (cfg_coarse_i),
        .cfg_fine_i   (cfg_fine_i),
        .cfg_and_i    (cfg_and_i),
        .err_clr_i    (err_clr_i),
        .fclk_o       (fclk_o),
        .sc_strobe_o  (sc_strobe_o),
        .we_strobe_o  (we_strobe_o),
        .cfg_err_o    (cfg_err_o)
    );

    function automatic int ratio_of(int c, int f);
        return (1 << c) * (f ? 2 : 1);
    endfunction

    // k counts edges after E0, the edge that first samples stop_i low
    function automatic logic exp_fclk(int k, int n);
        return ((k / n) % 2) == 1;
    endfunction

    function automatic logic exp_we(int k, int n, bit andm);
        if (!andm) return exp_fclk(k, n);
        return ((((k / n) + 1) / 2) % 2) == 1;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // stop, check quiet outputs (R3), then write config while stopped (R7)
    task automatic configure(int c, int f, bit a);
        @(negedge clk_i);
        stop_i = 1'b1;
        @(negedge clk_i);
        @(negedge clk_i);
        chk("R3 fclk low in stop", fclk_o, 0);
        chk("R3 sc low in stop", sc_strobe_o, 0);
        chk("R3 we low in stop", we_strobe_o, 0);
        cfg_coarse_i = c[1:0];
        cfg_fine_i   = f[0];
        cfg_and_i    = a;
        cfg_we_i     = 1'b1;
        err_clr_i    = 1'b1;
        @(negedge clk_i);
        cfg_we_i  = 1'b0;
        err_clr_i = 1'b0;
        chk("R7 no error on write in stop", cfg_err_o, 0);
    endtask

    task automatic run_pattern(int n, bit andm, bit inject);
        int len;
        len = 4 * n + 12;
        stop_i = 1'b0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk_i);
            if (k < n)       chk("R4 low before first rise", fclk_o, exp_fclk(k, n));
            else if (k == n) chk("R7 R4 first rise at new ratio", fclk_o, exp_fclk(k, n));
            else             chk("R2 fclk period", fclk_o, exp_fclk(k, n));
            chk("R6 sc equals fclk", sc_strobe_o, exp_fclk(k, n));
            chk(andm ? "R6 half-rate we" : "R5 we follows fclk", we_strobe_o, exp_we(k, n, andm));
            if (inject) begin
                if (k == 5) begin
                    cfg_coarse_i = ~cfg_coarse_i;
                    cfg_fine_i   = ~cfg_fine_i;
                    cfg_and_i    = ~cfg_and_i;
                    cfg_we_i     = 1'b1;
                end else if (k == 6) begin
                    cfg_we_i = 1'b0;
                    chk("R8 rejected write sets flag", cfg_err_o, 1);
                end else if (k == 8) begin
                    cfg_we_i  = 1'b1;
                    err_clr_i = 1'b1;
                end else if (k == 9) begin
                    chk("R9 set wins over clear", cfg_err_o, 1);
                    cfg_we_i = 1'b0;
                end else if (k == 10) begin
                    chk("R9 flag cleared", cfg_err_o, 0);
                    err_clr_i = 1'b0;
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk("R1 reset fclk", fclk_o, 0);
        chk("R1 reset sc", sc_strobe_o, 0);
        chk("R1 reset we", we_strobe_o, 0);
        chk("R1 reset err", cfg_err_o, 0);
        // R1: default ratio 1, NAND, without any write
        run_pattern(1, 1'b0, 1'b0);

        // directed corners: largest and smallest ratio in AND mode
        configure(3, 1, 1'b1);
        run_pattern(ratio_of(3, 1), 1'b1, 1'b0);
        configure(0, 0, 1'b1);
        run_pattern(1, 1'b1, 1'b0);
        // R8/R9: writes while running are rejected, waveform continues
        configure(1, 1, 1'b1);
        run_pattern(ratio_of(1, 1), 1'b1, 1'b1);
        configure(2, 0, 1'b0);
        run_pattern(ratio_of(2, 0), 1'b0, 1'b1);

        for (int i = 0; i < 10; i++) begin
            int c, f, a;
            c = $urandom_range(0, 3);
            f = $urandom_range(0, 1);
            a = $urandom_range(0, 1);
            configure(c, f, a[0]);
            run_pattern(ratio_of(c, f), a[0], ($urandom_range(0, 2) == 0));
        end

        configure(0, 0, 1'b0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule